// File: doc/BRIEF.md
# Window Threshold Alert with Latch

This block sits after an analog-to-digital conversion engine and looks at every finished result. Each result is a signed 16-bit value. The block compares it against a programmable upper limit and a programmable lower limit. When a result falls outside that window, the block pulls an open-drain alert line low. A status bit records which side of the window was crossed.

A mode input selects how the alert behaves:

- **Sticky mode.** The alert holds until one of two clear strobes arrives. One strobe marks a read of the result register. The other marks an alert-response handshake that this device won.
- **Follow mode.** The alert simply tracks the most recent comparison.

An enable input can release the line entirely, so the wire floats high and other devices sharing it are not disturbed.

The core is a two-state machine:

- **ST_QUIET.** The line is released.
- **ST_FIRING.** An alert is pending.

It has the following transitions:

- **T_HIT** (ST_QUIET to ST_FIRING): a done strobe with an out-of-window result.
- **T_REHIT** (ST_FIRING to ST_FIRING): a further out-of-window result, which refreshes the status bit.
- **T_CLEAR** (ST_FIRING to ST_QUIET): in sticky mode, a read strobe or a won-handshake strobe, with no out-of-window result in the same cycle.
- **T_FOLLOW** (ST_FIRING to ST_QUIET): in follow mode, a done strobe with an in-window result.

In every other case the state is held.

Top module: `thr_alert`

## Requirements
- R1: After reset the alert line is released (`alert_pull` = 0) and the status bit `side_hi` is 0.
- R2: The comparison is signed. A result counts as high only when it is strictly greater than `thr_hi`, and as low only when it is strictly less than `thr_lo`. A result equal to either limit is inside the window.
- R3: In sticky mode (`latch_mode` = 1), a done strobe with an out-of-window result drives `alert_pull` to 1 from the next cycle. The alert stays asserted through idle cycles and through later in-window results.
- R4: In sticky mode, a one-cycle `clr_read` pulse releases a pending alert from the next cycle.
- R5: In sticky mode, a one-cycle `clr_won` pulse releases a pending alert. A device that lost the handshake receives no strobe, and its alert stays asserted.
- R6: After a clear, a later out-of-window result asserts the alert again.
- R7: When a clear strobe and a done strobe with an out-of-window result occur in the same cycle, the alert remains asserted.
- R8: Every out-of-window result sets `side_hi` to 1 if it was high and to 0 if it was low. In-window results and clears leave `side_hi` unchanged.
- R9: In follow mode (`latch_mode` = 0), each done strobe sets the alert to that result's comparison outcome. The clear strobes have no effect in this mode.
- R10: While `alert_en` = 0, `alert_pull` is 0 but the pending state keeps being tracked. When `alert_en` returns to 1, that state appears on `alert_pull` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle strobe: `conv_result` holds a finished result |
| conv_result | input | 16 | Signed conversion result |
| thr_hi | input | 16 | Signed upper limit |
| thr_lo | input | 16 | Signed lower limit |
| latch_mode | input | 1 | 1 selects sticky mode, 0 selects follow mode |
| alert_en | input | 1 | 1 allows the line to be pulled, 0 releases it |
| clr_read | input | 1 | Strobe marking a read of the result register |
| clr_won | input | 1 | Strobe marking a won alert-response handshake |
| alert_pull | output | 1 | 1 pulls the open-drain alert line low |
| side_hi | output | 1 | 1 means the last crossing was high, 0 means it was low |

## Verification
The bench probes the following cases:

- **Exact limits.** Results equal to each limit are driven. A design using a non-strict compare would raise the alert there.
- **Signed compare.** Negative results are driven against a positive upper limit. A design comparing unsigned would see them as huge and report a high crossing.
- **Clear racing a new hit.** A clear strobe lands in the same cycle as a new out-of-window result. A design that lets the clear win would drop an alert it still owes.
- **Status bit hold.** The bench checks that `side_hi` survives in-window results and clears. A design that cleared it there would lose which side fired.
- **Mode behaviour.** Follow mode must ignore the clear strobes. The masked alert must reappear when re-enabled. A design that gated the state instead of the output would lose the pending alert.

// File: rtl/thr_alert_pkg.sv
package thr_alert_pkg;
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_FIRING = 1'b1
    } alert_st_e;

    typedef struct packed {
        logic hit_hi;
        logic hit_lo;
    } cmp_res_t;
endpackage

// File: rtl/thr_alert_cmp.sv
module thr_alert_cmp
    import thr_alert_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic signed [DATA_W-1:0] hi_lim,
    input  logic signed [DATA_W-1:0] lo_lim,
    output cmp_res_t                 res
);
    // Strict signed compares; the high side takes priority if the limits are crossed.
    always_comb begin
        res.hit_hi = (sample > hi_lim);
        res.hit_lo = !res.hit_hi && (sample < lo_lim);
    end
endmodule

// File: rtl/thr_alert_fsm.sv
module thr_alert_fsm
    import thr_alert_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     conv_done,
    input  cmp_res_t cmp,
    input  logic     latch_mode,
    input  logic     clr_read,
    input  logic     clr_won,
    output logic     firing,
    output logic     side_hi
);
    alert_st_e state, nxt;
    logic      hit;
    logic      clr;

    assign hit = conv_done && (cmp.hit_hi || cmp.hit_lo);
    assign clr = latch_mode && (clr_read || clr_won);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_QUIET: begin
                if (hit) nxt = ST_FIRING;                  // T_HIT
            end
            ST_FIRING: begin
                if (hit)                   nxt = ST_FIRING; // T_REHIT (R7)
                else if (latch_mode && clr) nxt = ST_QUIET; // T_CLEAR (R4, R5)
                else if (!latch_mode && conv_done)
                                           nxt = ST_QUIET;  // T_FOLLOW (R9)
            end
            default: nxt = ST_QUIET;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n)   side_hi <= 1'b0;
        else if (hit) side_hi <= cmp.hit_hi;
    end

    assign firing = (state == ST_FIRING);

    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && firing && !clr_read && !clr_won) |=> firing);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && clr_read && !(conv_done && (cmp.hit_hi || cmp.hit_lo))) |=> !firing);

    a_r5_won_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && clr_won && !(conv_done && (cmp.hit_hi || cmp.hit_lo))) |=> !firing);

    a_r7_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && (cmp.hit_hi || cmp.hit_lo)) |=> firing);

    a_r8_side_high: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && cmp.hit_hi) |=> side_hi);

    a_r8_side_low: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && cmp.hit_lo) |=> !side_hi);

    a_r8_side_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_done && (cmp.hit_hi || cmp.hit_lo)) |=> $stable(side_hi));

    a_r9_follow_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && conv_done && !cmp.hit_hi && !cmp.hit_lo) |=> !firing);
endmodule

// File: rtl/thr_alert.sv
module thr_alert
    import thr_alert_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic              latch_mode,
    input  logic              alert_en,
    input  logic              clr_read,
    input  logic              clr_won,
    output logic              alert_pull,
    output logic              side_hi
);
    cmp_res_t cmp;
    logic     firing;

    thr_alert_cmp #(.DATA_W(DATA_W)) u_cmp (
        .sample (signed'(conv_result)),
        .hi_lim (signed'(thr_hi)),
        .lo_lim (signed'(thr_lo)),
        .res    (cmp)
    );

    thr_alert_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_done  (conv_done),
        .cmp        (cmp),
        .latch_mode (latch_mode),
        .clr_read   (clr_read),
        .clr_won    (clr_won),
        .firing     (firing),
        .side_hi    (side_hi)
    );

    // Open-drain drive: only pull when enabled (R10)
    assign alert_pull = alert_en && firing;

    a_r10_released: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_en |-> !alert_pull);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!alert_pull && !side_hi));
endmodule

// File: tb/thr_alert_tb.sv
module thr_alert_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] conv_result = '0;
    logic [15:0] thr_hi = 16'sd1000;
    logic [15:0] thr_lo = -16'sd1000;
    logic        latch_mode = 1'b1;
    logic        alert_en = 1'b1;
    logic        clr_read = 1'b0;
    logic        clr_won = 1'b0;
    logic        alert_pull;
    logic        side_hi;

    typedef struct {
        logic  pull;
        logic  side;
        string req;
    } exp_t;

    exp_t  q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    logic  m_fire = 1'b0;
    logic  m_side = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    thr_alert u_dut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .latch_mode(latch_mode), .alert_en(alert_en),
        .clr_read(clr_read), .clr_won(clr_won), .alert_pull(alert_pull), .side_hi(side_hi)
    );

    // Driver: applies one cycle of stimulus and predicts the result from the requirements
    task automatic step(input logic done, input int res, input logic lm, input logic en,
                        input logic rd, input logic won, input string req);
        logic oh, ol;
        @(negedge clk);
        conv_done   = done;
        conv_result = 16'(res);
        latch_mode  = lm;
        alert_en    = en;
        clr_read    = rd;
        clr_won     = won;
        oh = done && (res > $signed(thr_hi));
        ol = done && !oh && (res < $signed(thr_lo));
        if (oh || ol) begin
            m_fire = 1'b1;
            m_side = oh;
        end else if (lm) begin
            if (rd || won) m_fire = 1'b0;
        end else if (done) begin
            m_fire = 1'b0;
        end
        q.push_back('{pull: m_fire && en, side: m_side, req: req});
    endtask

    // Monitor: compares mid-cycle after the edge that consumed the stimulus
    always @(posedge clk) begin
        #5;
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (alert_pull !== e.pull || side_hi !== e.side) begin
                n_bad++;
                $display("FAIL %s: pull=%b side=%b expected pull=%b side=%b",
                         e.req, alert_pull, side_hi, e.pull, e.side);
            end
        end
    end

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        n_cmp++;   // R1 reset state
        if (alert_pull !== 1'b0 || side_hi !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: pull=%b side=%b expected pull=0 side=0", alert_pull, side_hi);
        end
        @(negedge clk) rst_n = 1'b1;

        step(1, 500,    1, 1, 0, 0, "R2 inside");
        step(1, 1000,   1, 1, 0, 0, "R2 equal upper");
        step(1, -1000,  1, 1, 0, 0, "R2 equal lower, signed");
        step(1, 1001,   1, 1, 0, 0, "R3 high hit");
        step(0, 0,      1, 1, 0, 0, "R3 idle hold");
        step(1, 0,      1, 1, 0, 0, "R3 R8 in-window hold");
        step(0, 0,      1, 1, 0, 0, "R5 lost handshake keeps");
        step(0, 0,      1, 1, 1, 0, "R4 read clears");
        step(1, -1001,  1, 1, 0, 0, "R6 R8 low rehit");
        step(0, 0,      1, 1, 0, 1, "R5 won clears");
        step(1, -2,     1, 1, 0, 0, "R2 negative inside");
        step(1, -32768, 1, 1, 1, 0, "R7 hit beats read");
        step(1, 32767,  1, 1, 0, 1, "R7 hit beats won");
        step(0, 0,      1, 1, 1, 0, "R4 clear again");
        step(1, 32767,  1, 0, 0, 0, "R10 masked");
        step(0, 0,      1, 1, 0, 0, "R10 unmasked shows state");
        step(0, 0,      0, 1, 1, 1, "R9 clears ignored");
        step(1, 5,      0, 1, 0, 0, "R9 follow drop");
        step(1, 2000,   0, 1, 0, 0, "R9 follow high");
        step(0, 0,      0, 1, 0, 0, "R9 no strobe holds");
        step(1, -5000,  0, 1, 0, 0, "R9 R8 follow low");
        step(0, 0,      0, 1, 0, 0, "R8 idle side kept");

        @(negedge clk);
        conv_done = 1'b0;
        clr_read  = 1'b0;
        clr_won   = 1'b0;
        repeat (3) @(posedge clk);
        #8;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule